// File: doc/BRIEF.md
# Bidirectional Loadable Counter

This block holds an N-bit count (4 bits by default) in a state register and moves it by one step per enabled clock edge. A direction input picks the step: upward through a ripple of half adders seeded with a constant one at bit 0, or downward through an adder whose second operand is the all-ones word, which subtracts one in two's complement. The step arithmetic wraps modulo 2^N in both directions.

Two synchronous controls override counting. A clear input forces zero. A load input copies a parallel data word into the register. A terminal-count flag is computed from the present value and the direction, with no register in between. It goes high at the top of the range (all ones) when counting upward and at the bottom (all zeros) when counting downward. A parent block uses this flag to spot the last step before a wrap.

Top module: `updn_counter`

## Requirements
- R1: After reset, and on any edge with clear_i=1, the count becomes zero. Clear takes priority over load and enable.
- R2: On an edge with clear_i=0 and load_i=1, the count takes load_val_i. Load takes priority over enable.
- R3: On an edge with clear_i=0, load_i=0 and step_en_i=1 with dir_up_i=1, the count becomes count+1 modulo 2^N.
- R4: On an edge with clear_i=0, load_i=0 and step_en_i=1 with dir_up_i=0, the count becomes count-1 modulo 2^N.
- R5: Counting up wraps from all ones to zero, and counting down wraps from zero to all ones.
- R6: On an edge with clear_i=0, load_i=0 and step_en_i=0, the count holds its value, whatever dir_up_i is.
- R7: When dir_up_i=1, term_o is 1 exactly when every count bit is 1. When dir_up_i=0, term_o is 1 exactly when every count bit is 0. term_o follows the count and direction in the same cycle and does not depend on step_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear to zero |
| load_i | input | 1 | Synchronous parallel load |
| load_val_i | input | WIDTH | Value to load |
| step_en_i | input | 1 | Count enable |
| dir_up_i | input | 1 | 1 = count up, 0 = count down |
| count_o | output | WIDTH | Present count |
| term_o | output | 1 | Direction-aware terminal count |

## Verification
A wrong step or a wrong priority shows on count_o one edge after the cycle where it occurs. Because the bench predicts every edge, each such error is caught in that same cycle. A bad carry in the half-adder chain or the all-ones adder shows only at certain bit patterns. For that reason, every start value is swept in both directions, including the wrap points. A fault in the terminal-count detector shows on term_o with no delay, so the flag is compared for every count value under both directions and both enable settings.

// File: rtl/updn_counter_pkg.sv
package updn_counter_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/updn_incr.sv
module updn_incr #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] val_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  logic [WIDTH:0] chain;
  assign chain[0] = 1'b1;
  for (genvar i = 0; i < WIDTH; i++) begin : g_ha
    assign sum_o[i]   = val_i[i] ^ chain[i];
    assign chain[i+1] = val_i[i] & chain[i];
  end
  assign carry_o = chain[WIDTH];
endmodule

// File: rtl/updn_decr.sv
module updn_decr #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] val_i,
  output logic [WIDTH-1:0] diff_o,
  output logic             carry_o
);
  logic [WIDTH:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    // full adder with second operand bit fixed at 1
    assign diff_o[i]   = ~(val_i[i] ^ chain[i]);
    assign chain[i+1]  = val_i[i] | chain[i];
  end
  assign carry_o = chain[WIDTH];
endmodule

// File: rtl/updn_term.sv
module updn_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             up_i,
  output logic             all_one_o,
  output logic             all_zero_o,
  output logic             term_o
);
  assign all_one_o  = &val_i;
  assign all_zero_o = ~|val_i;
  assign term_o     = up_i ? all_one_o : all_zero_o;
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             step_en_i,
  input  logic             dir_up_i,
  output logic [WIDTH-1:0] count_o,
  output logic             term_o
);
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONES = '1;

  function automatic cnt_op_e pick_op(logic clr, logic ld, logic en);
    if (clr)     return OP_CLEAR;
    else if (ld) return OP_LOAD;
    else if (en) return OP_STEP;
    else         return OP_HOLD;
  endfunction

  logic [WIDTH-1:0] cnt_q, cnt_d, inc_val, dec_val, step_val;
  logic             inc_co, dec_co, all_one, all_zero;
  cnt_op_e          op;

  updn_incr #(.WIDTH(WIDTH)) u_incr (.val_i(cnt_q), .sum_o(inc_val), .carry_o(inc_co));
  updn_decr #(.WIDTH(WIDTH)) u_decr (.val_i(cnt_q), .diff_o(dec_val), .carry_o(dec_co));
  updn_term #(.WIDTH(WIDTH)) u_term (.val_i(cnt_q), .up_i(dir_up_i),
                                     .all_one_o(all_one), .all_zero_o(all_zero), .term_o(term_o));

  assign step_val = dir_up_i ? inc_val : dec_val;
  assign op       = pick_op(clear_i, load_i, step_en_i);

  always_comb begin
    unique case (op)
      OP_CLEAR: cnt_d = ZERO;
      OP_LOAD:  cnt_d = load_val_i;
      OP_STEP:  cnt_d = step_val;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= ZERO;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == ZERO)); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && load_i) |=> (count_o == $past(load_val_i))); // R2
  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !load_i && step_en_i && dir_up_i) |=> (count_o == $past(count_o) + 1'b1)); // R3
  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !load_i && step_en_i && !dir_up_i) |=> (count_o == $past(count_o) - 1'b1)); // R4
  AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !load_i && step_en_i && dir_up_i && all_one) |=> (count_o == ZERO)); // R5
  AST_DOWN_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !load_i && step_en_i && !dir_up_i && all_zero) |=> (count_o == ONES)); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !load_i && !step_en_i) |=> $stable(count_o)); // R6
  AST_CARRY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_co == all_one) && (dec_co == !all_zero)); // R7
endmodule

// File: tb/updn_counter_tb.sv
module updn_counter_tb;
  localparam int W = 4;
  localparam int N = 1 << W;
  localparam time CLK_PER = 10ns;

  logic clk = 0, rst_n = 0, clr = 0, ld = 0, en = 0, up = 1;
  logic [W-1:0] ldv = '0;
  logic [W-1:0] cnt;
  logic term;
  int errors = 0, checks = 0;
  int model = 0;

  always #(CLK_PER/2) clk = ~clk;

  updn_counter #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .load_i(ld), .load_val_i(ldv),
    .step_en_i(en), .dir_up_i(up), .count_o(cnt), .term_o(term));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive controls at the falling edge, let one rising edge pass, sample at the next falling edge
  task automatic tick(logic c, logic l, logic [W-1:0] v, logic e, logic u);
    clr = c; ld = l; ldv = v; en = e; up = u;
    @(posedge clk);
    if (c) model = 0;
    else if (l) model = v;
    else if (e) model = u ? (model + 1) % N : (model + N - 1) % N;
    @(negedge clk);
  endtask

  function automatic int exp_term(int m, logic u);
    return u ? (m == N-1) : (m == 0);
  endfunction

  initial begin
    #(CLK_PER*100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset", cnt, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", cnt, 0);
    // R3/R5 up sweep through two wraps
    for (int i = 0; i < 2*N; i++) begin
      tick(0, 0, '0, 1, 1);
      chk("R3/R5 up step", cnt, model);
    end
    // R4/R5 down sweep through two wraps
    for (int i = 0; i < 2*N; i++) begin
      tick(0, 0, '0, 1, 0);
      chk("R4/R5 down step", cnt, model);
    end
    // R2 load, R6 hold, R7 terminal for every value, both dirs and enables
    for (int v = 0; v < N; v++) begin
      tick(0, 1, v[W-1:0], 1, 1);
      chk("R2 load", cnt, v);
      for (int d = 0; d < 2; d++) begin
        for (int e = 0; e < 2; e++) begin
          clr = 0; ld = 0; en = e[0]; up = d[0];
          #1;
          chk("R7 term", term, exp_term(model, d[0]));
        end
        tick(0, 0, '0, 0, d[0]);
        chk("R6 hold", cnt, v);
      end
      tick(0, 0, '0, 1, v[0]);
      chk("R3/R4 step after load", cnt, model);
    end
    // wrap points explicitly
    tick(0, 1, {W{1'b1}}, 0, 1); tick(0, 0, '0, 1, 1);
    chk("R5 up wrap", cnt, 0);
    tick(0, 0, '0, 1, 0);
    chk("R5 down wrap", cnt, N-1);
    // R1 priority over load, R2 priority over enable
    tick(1, 1, 4'd5, 1, 1);
    chk("R1 clear wins", cnt, 0);
    tick(0, 1, 4'd9, 1, 0);
    chk("R2 load wins", cnt, 9);
    tick(1, 0, '0, 0, 0);
    chk("R1 clear alone", cnt, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule